// File: doc/BRIEF.md
# Double-Buffered Audio Sample DMA Controller

This block feeds an audio output stage with 16-bit stereo samples that it pulls straight from memory. Software queues a playback buffer by writing a start address and then a byte length through a small register port. The controller keeps one transfer playing and a second one waiting behind it. When the playing buffer runs dry, the waiting one takes over on the same clock edge, so the output stage never sees a gap. An interrupt is raised when a transfer begins rather than when it ends, which gives software the whole of the new buffer's playing time to prepare the one after it.

No samples are stored inside the block. Each single-cycle sample request from the output stage turns into exactly one 32-bit memory read, and that word is the left/right pair. Requests made while nothing is playing are answered with silence. The playback address is held as a 13-bit low half plus a high half, and the carry between them arrives one cycle late. As a result, a buffer that ends exactly on an 8 KiB boundary pushes the next buffer's start address up by 0x2000. This behaviour is reproduced on purpose.

Top module: `audio_dma_ctrl`

## Requirements
- R1: After reset the interrupt, the memory request and the sample valid output are low, and both the status word and the remaining-length read are zero.
- R2: Register index 0 holds a 24-bit start address with bits [2:0] forced to zero. A length write keeps bits [17:3] of the data and forces bits [2:0] to zero. A length that is zero after this masking queues nothing.
- R3: A length write (index 1) queues the pair of the held address and the masked length. It does so when the waiting slot is empty or is being promoted in that cycle; otherwise the write is dropped. At most two transfers are held.
- R4: A read of index 3 returns the status word. Bit 31 and bit 0 are set when a transfer waits behind a playing one. Bit 30 is set while a transfer plays. Bit 25 holds the enable bit. All other bits are zero.
- R5: A read of index 1 returns the bytes still to be fetched from the playing transfer in bits [17:0], or zero when nothing is playing. Reads of indices 0, 2, 4, 5, 6 and 7 return the same value. Writes to indices 4 to 7 change nothing.
- R6: Bit 0 of a control write (index 2) is the enable. While it is clear no waiting transfer starts, but a playing transfer runs on to its end.
- R7: The interrupt goes high on the edge where a transfer starts. Any status write (index 3) clears it, and a start in the same cycle wins over the clear.
- R8: While a transfer plays, a sample request raises the memory request on the next edge. The request holds with a steady address until the memory valid is seen. The valid drops the request, presents the word with sample valid on the following cycle, and advances the address by 4 while reducing the remaining count by 4.
- R9: A sample request while nothing plays gives sample valid with all-zero data on the next cycle. A sample request while a memory read is outstanding is ignored.
- R10: When the last word of a playing transfer arrives and a transfer is waiting with the enable set, the waiting one starts on that same edge.
- R11: A crossing of an 8 KiB boundary in the middle of a transfer is addressed correctly. When a transfer's final word leaves the address exactly on a multiple of 0x2000, the next transfer to start, whether already waiting or queued later, fetches from its programmed address plus 0x2000 (modulo 2^24).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| irq | output | 1 | Transfer-start interrupt |
| samp_req | input | 1 | Single-cycle request for the next sample |
| samp_valid | output | 1 | Sample data valid |
| samp_data | output | 32 | Left/right 16-bit pair |
| mem_req | output | 1 | Memory read request, held until mem_valid |
| mem_addr | output | 24 | Memory byte address |
| mem_valid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data |

## Verification
The bench builds the block with its default widths: a 24-bit address, an 18-bit length and a 13-bit low address half. With these widths, short buffers placed just below a page end reach both the mid-transfer crossing and the end-on-boundary carry within a few dozen cycles. The carry is checked twice: once while a buffer is already waiting, and once where it is held across an idle stretch and lands on a buffer queued later. Queue-full drops, a disable that stalls promotion, idle silence and overlapping sample requests are all compared on every clock against a behavioural model that works on whole integer addresses.

// File: rtl/audio_dma_ctrl.sv
module audio_dma_ctrl #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 18,
  parameter int PAGE_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  input  logic              samp_req,
  output logic              samp_valid,
  output logic [31:0]       samp_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [31:0]       mem_rdata
);
  localparam int HI_W = ADDR_W - PAGE_W;

  logic [ADDR_W-1:0] addr_q, pend_addr;
  logic [LEN_W-1:0]  pend_len, act_rem;
  logic [PAGE_W-1:0] act_lo, lo_n;
  logic [HI_W-1:0]   act_hi;
  logic              en_q, act_v, pend_v, carry_q, wait_q, sv_q, irq_q, lo_c;
  logic [31:0]       sd_q;

  logic wr_addr, wr_len, wr_ctl, wr_stat, fetch_done, last, promote, accept, full;
  logic [LEN_W-1:0] len_in;
  logic unused_bits;

  assign wr_addr    = reg_we && reg_addr == 3'd0;
  assign wr_len     = reg_we && reg_addr == 3'd1;
  assign wr_ctl     = reg_we && reg_addr == 3'd2;
  assign wr_stat    = reg_we && reg_addr == 3'd3;
  assign len_in     = {reg_wdata[LEN_W-1:3], 3'b000};
  assign fetch_done = wait_q && mem_valid;
  assign last       = fetch_done && act_rem == LEN_W'(4);
  assign promote    = pend_v && en_q && (!act_v || last);
  assign accept     = wr_len && len_in != '0 && (!pend_v || promote);
  assign full       = act_v && pend_v;
  assign {lo_c, lo_n} = {1'b0, act_lo} + (PAGE_W+1)'(4);
  assign unused_bits = ^{reg_wdata[31:ADDR_W], reg_wdata[2:0]};

  assign reg_rdata  = (reg_addr == 3'd3) ? {full, act_v, 4'b0000, en_q, 24'd0, full}
                                         : {{(32-LEN_W){1'b0}}, act_rem};
  assign irq        = irq_q;
  assign samp_valid = sv_q;
  assign samp_data  = sd_q;
  assign mem_req    = wait_q;
  assign mem_addr   = {act_hi, act_lo};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0; en_q <= 1'b0; irq_q <= 1'b0;
      act_v <= 1'b0; act_lo <= '0; act_hi <= '0; act_rem <= '0;
      pend_v <= 1'b0; pend_addr <= '0; pend_len <= '0;
      carry_q <= 1'b0; wait_q <= 1'b0; sv_q <= 1'b0; sd_q <= '0;
    end else begin
      if (wr_addr) addr_q <= {reg_wdata[ADDR_W-1:3], 3'b000};
      if (wr_ctl)  en_q <= reg_wdata[0];

      if (promote)      irq_q <= 1'b1;
      else if (wr_stat) irq_q <= 1'b0;

      sv_q <= 1'b0;
      if (fetch_done) begin
        sv_q <= 1'b1;
        sd_q <= mem_rdata;
      end else if (samp_req && !act_v) begin
        sv_q <= 1'b1;
        sd_q <= '0;
      end

      if (fetch_done)              wait_q <= 1'b0;
      else if (samp_req && act_v)  wait_q <= 1'b1;

      if (fetch_done) begin
        act_lo  <= lo_n;
        act_rem <= act_rem - LEN_W'(4);
      end
      if (fetch_done && lo_c)
        carry_q <= 1'b1;
      else if (carry_q && act_v) begin
        act_hi  <= act_hi + HI_W'(1);
        carry_q <= 1'b0;
      end

      if (promote) begin
        act_v   <= 1'b1;
        act_lo  <= pend_addr[PAGE_W-1:0];
        act_hi  <= pend_addr[ADDR_W-1:PAGE_W];
        act_rem <= pend_len;
        pend_v  <= 1'b0;
      end else if (last) begin
        act_v <= 1'b0;
      end

      if (accept) begin
        pend_v    <= 1'b1;
        pend_addr <= addr_q;
        pend_len  <= len_in;
      end
    end
  end

  assert_memreq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));
  assert_word_to_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_valid) |=> (samp_valid && !mem_req));
  assert_remaining_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_valid && act_rem != LEN_W'(4)) |=> (act_rem == $past(act_rem) - LEN_W'(4)));
  assert_irq_on_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_v) |-> irq);
  assert_hold_when_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !act_v) |=> !act_v);
  assert_idle_silence_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_req && !act_v) |=> (samp_valid && samp_data == 32'd0));
endmodule

// File: tb/audio_dma_ctrl_tb.sv
`timescale 1ns/1ps
module audio_dma_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq, samp_req = 1'b0, samp_valid, mem_req, mem_valid = 1'b0;
  logic [31:0] samp_data, mem_rdata = '0;
  logic [23:0] mem_addr;

  always #2 clk = ~clk;

  audio_dma_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .samp_req(samp_req), .samp_valid(samp_valid), .samp_data(samp_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .mem_rdata(mem_rdata));

  int total = 0, failed = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // memory responder: answers after 2 waiting cycles
  int lat = 0;
  always @(negedge clk) begin
    if (mem_valid) mem_valid = 1'b0;
    else if (mem_req) begin
      if (lat == 2) begin
        mem_valid = 1'b1;
        mem_rdata = {8'hC3, mem_addr};
        lat = 0;
      end else lat++;
    end
  end

  // behavioural reference model
  int m_addr, m_en, m_irq, m_act, m_aaddr, m_rem, m_pend, m_paddr, m_plen, m_bump, m_wait, m_sv;
  logic [31:0] m_sd;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_addr = 0; m_en = 0; m_irq = 0; m_act = 0; m_aaddr = 0; m_rem = 0;
      m_pend = 0; m_paddr = 0; m_plen = 0; m_bump = 0; m_wait = 0; m_sv = 0; m_sd = 0;
    end else begin
      int fd, lst, prom, acc, wlen;
      fd   = m_wait && mem_valid;
      lst  = fd && m_rem == 4;
      prom = m_pend && m_en && (!m_act || lst);
      wlen = int'(reg_wdata & 32'h3FFF8);
      acc  = reg_we && reg_addr == 1 && wlen != 0 && (!m_pend || prom);
      m_sv = 0;
      if (fd) begin m_sv = 1; m_sd = mem_rdata; end
      else if (samp_req && !m_act) begin m_sv = 1; m_sd = 0; end
      if (fd) m_wait = 0; else if (samp_req && m_act) m_wait = 1;
      if (fd) begin
        m_aaddr = (m_aaddr + 4) % 32'h1000000;
        m_rem -= 4;
        if (lst && m_aaddr % 8192 == 0) m_bump = 1;
      end
      if (prom) begin
        m_act = 1; m_aaddr = (m_paddr + (m_bump ? 8192 : 0)) % 32'h1000000;
        m_bump = 0; m_rem = m_plen; m_pend = 0;
      end else if (lst) m_act = 0;
      if (prom) m_irq = 1; else if (reg_we && reg_addr == 3) m_irq = 0;
      if (acc) begin m_pend = 1; m_paddr = m_addr; m_plen = wlen; end
      if (reg_we && reg_addr == 0) m_addr = int'(reg_wdata & 32'hFFFFF8);
      if (reg_we && reg_addr == 2) m_en = int'(reg_wdata[0]);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(irq == 1'(m_irq), "R7 irq vs model", 32'(irq), 32'(m_irq));
      chk(mem_req == 1'(m_wait), "R8 mem_req vs model", 32'(mem_req), 32'(m_wait));
      if (mem_req) chk(mem_addr == 24'(m_aaddr), "R11 mem_addr vs model", 32'(mem_addr), 32'(m_aaddr));
      chk(samp_valid == 1'(m_sv), "R9 samp_valid vs model", 32'(samp_valid), 32'(m_sv));
      if (samp_valid) chk(samp_data == m_sd, "R8 samp_data vs model", samp_data, m_sd);
    end
  end

  function automatic logic [31:0] model_rd(input int idx);
    if (idx == 3) return {1'(m_act && m_pend), 1'(m_act), 4'b0, 1'(m_en), 24'd0, 1'(m_act && m_pend)};
    return 32'(m_rem);
  endfunction

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = 3'(idx); reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input int idx, input logic [31:0] exp, input string tag);
    reg_addr = 3'(idx); #1;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
    chk(reg_rdata == model_rd(idx), {tag, " model"}, reg_rdata, model_rd(idx));
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic get_sample(output logic [31:0] a, output logic [31:0] d, input bit extra);
    bit seen = 0;
    a = '0; d = '1;
    @(negedge clk); samp_req = 1'b1;
    @(negedge clk); samp_req = 1'b0;
    for (int i = 0; i < 30; i++) begin
      if (mem_req && !seen) begin
        a = 32'(mem_addr); seen = 1;
        if (extra) begin samp_req = 1'b1; @(negedge clk); samp_req = 1'b0; end
      end
      if (samp_valid) begin d = samp_data; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failed++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, d;
    cyc(3); rst_n = 1'b1; cyc(1);
    chk(irq == 0 && mem_req == 0 && samp_valid == 0, "R1 outputs after reset", {irq, mem_req, samp_valid}, 0);
    rd(3, 32'h0, "R1 status after reset");
    rd(1, 32'h0, "R1 length after reset");

    wr(2, 1); wr(1, 7); cyc(3);
    rd(3, 32'h0200_0000, "R2 zero length queues nothing");

    wr(2, 0); wr(0, 32'hFF00_1FEB); wr(1, 32'h0000_001F); cyc(3);
    rd(3, 32'h0, "R6 disabled, nothing starts");
    wr(0, 32'h2000); wr(1, 32'h10); // dropped: slot occupied (R3)
    wr(2, 1); cyc(1);
    rd(3, 32'h4200_0000, "R4 busy and enable");
    chk(irq == 1, "R7 irq at start", 32'(irq), 1);
    rd(1, 24, "R5 remaining length");
    rd(0, 24, "R5 mirror idx0"); rd(2, 24, "R5 mirror idx2");
    rd(4, 24, "R5 mirror idx4"); rd(5, 24, "R5 mirror idx5");
    wr(4, 32'hFFFF); wr(5, 32'hF);
    rd(1, 24, "R5 rate writes ignored");

    wr(0, 32'h3000); wr(1, 32'h10);
    rd(3, 32'hC200_0001, "R4 full flags");
    wr(0, 32'h9000); wr(1, 8); // dropped while full (R3)
    wr(3, 0); cyc(1);
    chk(irq == 0, "R7 irq cleared by status write", 32'(irq), 0);

    get_sample(a, d, 0);
    chk(a == 32'h001FE8, "R2 masked start address", a, 32'h001FE8);
    chk(d == 32'hC300_1FE8, "R8 sample word", d, 32'hC300_1FE8);
    rd(1, 20, "R8 remaining after one sample");
    for (int i = 0; i < 5; i++) get_sample(a, d, 0);
    chk(irq == 1, "R10 next transfer started at once", 32'(irq), 1);
    rd(1, 16, "R10 promoted length");
    get_sample(a, d, 0);
    chk(a == 32'h005000, "R11 boundary carry onto waiting buffer", a, 32'h005000);
    for (int i = 0; i < 3; i++) get_sample(a, d, 0);
    get_sample(a, d, 0);
    chk(d == 32'h0, "R9 idle sample is silence", d, 0);
    rd(3, 32'h0200_0000, "R3 dropped write left queue empty");

    wr(0, 32'h7FF8); wr(1, 16); cyc(2); wr(0, 32'hA000); wr(1, 8);
    get_sample(a, d, 1);
    chk(a == 32'h007FF8, "R9 overlapping request ignored", a, 32'h7FF8);
    get_sample(a, d, 0);
    get_sample(a, d, 0);
    chk(a == 32'h008000, "R11 mid-transfer crossing", a, 32'h8000);
    wr(2, 0);
    get_sample(a, d, 0); cyc(3);
    rd(3, 32'h0, "R6 waiting buffer held while disabled");
    wr(2, 1); cyc(1);
    get_sample(a, d, 0);
    chk(a == 32'h00A000, "R11 no carry without boundary", a, 32'hA000);
    get_sample(a, d, 0);

    wr(0, 32'hBFF8); wr(1, 8);
    get_sample(a, d, 0); get_sample(a, d, 0); cyc(5);
    wr(0, 32'h10000); wr(1, 8); cyc(1);
    get_sample(a, d, 0);
    chk(a == 32'h012000, "R11 carry held across idle", a, 32'h12000);
    get_sample(a, d, 0); cyc(4);

    finished = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule